// File: doc/BRIEF.md
# Serial Sample Interface Interrupt Aggregator

This block turns the activity of a serial telephony-style sample interface and its DMA buffer engine into one interrupt request. It generates the events itself. It tracks a DMA buffer pointer with a programmable length. For each of two channels it watches the handshake between hardware and software on the receive and transmit holding registers. It detects overruns and underruns. It also watches the raw serial clock, so that clock activity can wake the system.

Each event sets a sticky status bit. Software clears a status bit by writing 1 to it. Each status bit is ANDed with its own enable bit, and the OR of the results drives a single request line to the system interrupt controller. A small register port gives software read access to status and read/write access to the enable bits and the buffer length. A register read returns its data one cycle after the request.

Top module: `tdm_event_irq`

## Requirements
- R1: After reset, status reads 0x00, enable reads 0x00, `irq` is low, the buffer length reads 0xFF and the buffer pointer is 0.
- R2: Register port addresses: 0 is status, 1 is enable and 2 is buffer length. A read request `reg_rd` returns `reg_rdata` with `reg_rvalid` high on the next cycle. Status and enable share one bit layout: bit 0 bus error, bit 1 halfway, bit 2 end of buffer, bit 3 pointer step, bit 4 channel 0 ready, bit 5 channel 1 ready, bit 6 clock activity, bit 7 holding-register error.
- R3: `irq` is high exactly when some status bit and its matching enable bit are both 1.
- R4: Status bits stay set until software writes 1 to that bit at address 0. An event that arrives in the same cycle as the clearing write leaves the bit set.
- R5: A `bus_err` pulse sets status bit 0.
- R6: Every `dma_step` pulse sets status bit 3 and advances the pointer. After the position length-1 the pointer wraps to 0. A write to the length register restarts the pointer at 0.
- R7: Status bit 1 is set when a step brings the pointer to length/2, rounded down.
- R8: Status bit 2 is set when a step brings the pointer to length-1.
- R9: A `rx_fill` pulse on channel 0 or channel 1 sets status bit 4 or bit 5 respectively.
- R10: Status bit 7 is set in two cases. The first is a `rx_fill` on a channel whose previous fill has not been taken by `rx_take`. The second is a `tx_drain` on a channel with no `tx_load` since its last drain. Normal alternation leaves the bit clear.
- R11: Any edge on `sclk` sets status bit 6 by the end of the 16-cycle window in which the edge is seen. A quiet `sclk` never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_err | input | 1 | DMA bus error pulse |
| dma_step | input | 1 | DMA buffer pointer step pulse |
| rx_fill | input | 2 | Hardware wrote a new sample to a channel's receive holding register |
| rx_take | input | 2 | Software/DMA read a channel's receive holding register |
| tx_drain | input | 2 | Hardware emptied a channel's transmit holding register |
| tx_load | input | 2 | Software/DMA wrote a channel's transmit holding register |
| sclk | input | 1 | Raw serial interface clock, asynchronous |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every event input is a clean single-cycle pulse in the system clock domain. They also assume that the buffer length is never programmed below 2, because the pointer range check is only meaningful for such lengths. The stimulus drives each event for exactly one cycle from tasks. It programs only the lengths 8 and 5, and it toggles `sclk` slowly enough that the synchronizer sees every edge.

// File: rtl/tdm_evt_pkg.sv
package tdm_evt_pkg;
  localparam int NUM_SRC = 8;
  localparam int NUM_CH  = 2;

  localparam int BIT_BUS  = 0;
  localparam int BIT_HALF = 1;
  localparam int BIT_END  = 2;
  localparam int BIT_STEP = 3;
  localparam int BIT_CH0  = 4;
  localparam int BIT_CH1  = 5;
  localparam int BIT_ACT  = 6;
  localparam int BIT_ERR  = 7;

  localparam logic [1:0] ADR_STATUS = 2'd0;
  localparam logic [1:0] ADR_ENABLE = 2'd1;
  localparam logic [1:0] ADR_LENGTH = 2'd2;

  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/tdm_rst_sync.sv
module tdm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;
endmodule

// File: rtl/tdm_bufptr_track.sv
module tdm_bufptr_track #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             len_wr,
  input  logic [PTR_W-1:0] len_wdata,
  output logic [PTR_W-1:0] ptr_o,
  output logic [PTR_W-1:0] len_o,
  output logic             step_evt,
  output logic             half_evt,
  output logic             end_evt
);
  localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [PTR_W-1:0] len_q, len_d;
  logic [PTR_W-1:0] last_pos;
  logic [PTR_W-1:0] ptr_inc;
  logic             at_last;
  logic             adv;

  always_comb begin
    last_pos = len_q - ONE;
    ptr_inc  = ptr_q + ONE;
    at_last  = (ptr_q == last_pos);
    adv      = step && !len_wr;
    len_d    = len_wr ? len_wdata : len_q;
    if (len_wr)       ptr_d = '0;
    else if (step)    ptr_d = at_last ? '0 : ptr_inc;
    else              ptr_d = ptr_q;
    step_evt = step;
    half_evt = adv && !at_last && (ptr_inc == (len_q >> 1));
    end_evt  = adv && !at_last && (ptr_inc == last_pos);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      len_q <= '1;
    end else begin
      ptr_q <= ptr_d;
      len_q <= len_d;
    end
  end

  assign ptr_o = ptr_q;
  assign len_o = len_q;
endmodule

// File: rtl/tdm_hold_track.sv
module tdm_hold_track (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_fill,
  input  logic rx_take,
  input  logic tx_drain,
  input  logic tx_load,
  output logic ready_evt,
  output logic err_evt
);
  logic rx_full_q, rx_full_d;
  logic tx_pend_q, tx_pend_d;
  logic overrun, underrun;

  always_comb begin
    if (rx_fill)      rx_full_d = 1'b1;
    else if (rx_take) rx_full_d = 1'b0;
    else              rx_full_d = rx_full_q;

    if (tx_drain)     tx_pend_d = 1'b0;
    else if (tx_load) tx_pend_d = 1'b1;
    else              tx_pend_d = tx_pend_q;

    overrun   = rx_fill && rx_full_q && !rx_take;
    underrun  = tx_drain && !tx_pend_q && !tx_load;
    ready_evt = rx_fill;
    err_evt   = overrun || underrun;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full_q <= 1'b0;
      tx_pend_q <= 1'b0;
    end else begin
      rx_full_q <= rx_full_d;
      tx_pend_q <= tx_pend_d;
    end
  end
endmodule

// File: rtl/tdm_clk_activity.sv
module tdm_clk_activity #(
  parameter int WIN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic act_evt
);
  localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [CW-1:0] WIN_LAST = CW'(WIN - 1);

  logic [2:0]    sync_q;
  logic [CW-1:0] win_q, win_d;
  logic          seen_q, seen_d;
  logic          edge_hit;
  logic          win_end;

  always_comb begin
    edge_hit = sync_q[2] ^ sync_q[1];
    win_end  = (win_q == WIN_LAST);
    win_d    = win_end ? '0 : win_q + 1'b1;
    seen_d   = win_end ? 1'b0 : (seen_q || edge_hit);
    act_evt  = win_end && (seen_q || edge_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      win_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], sclk};
      win_q  <= win_d;
      seen_q <= seen_d;
    end
  end
endmodule

// File: rtl/tdm_event_irq.sv
module tdm_event_irq
  import tdm_evt_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int WIN   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_err,
  input  logic       dma_step,
  input  logic [1:0] rx_fill,
  input  logic [1:0] rx_take,
  input  logic [1:0] tx_drain,
  input  logic [1:0] tx_load,
  input  logic       sclk,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       reg_rvalid,
  output logic       irq
);
  logic             rst_n_s;
  src_vec_t         status_q, status_d;
  src_vec_t         enable_q, enable_d;
  src_vec_t         set_vec, clr_vec;
  logic [7:0]       rdata_q, rdata_d;
  logic             rvalid_q;
  logic [PTR_W-1:0] ptr_w, len_w;
  logic             len_wr;
  logic             step_evt, half_evt, end_evt, act_evt;
  logic [NUM_CH-1:0] ready_evt, err_evt;

  tdm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign len_wr = reg_wr && (reg_addr == ADR_LENGTH);

  tdm_bufptr_track #(.PTR_W(PTR_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .step      (dma_step),
    .len_wr    (len_wr),
    .len_wdata (reg_wdata[PTR_W-1:0]),
    .ptr_o     (ptr_w),
    .len_o     (len_w),
    .step_evt  (step_evt),
    .half_evt  (half_evt),
    .end_evt   (end_evt)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tdm_hold_track u_hold (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .rx_fill   (rx_fill[c]),
      .rx_take   (rx_take[c]),
      .tx_drain  (tx_drain[c]),
      .tx_load   (tx_load[c]),
      .ready_evt (ready_evt[c]),
      .err_evt   (err_evt[c])
    );
  end

  tdm_clk_activity #(.WIN(WIN)) u_act (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .sclk    (sclk),
    .act_evt (act_evt)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[BIT_BUS]  = bus_err;
    set_vec[BIT_HALF] = half_evt;
    set_vec[BIT_END]  = end_evt;
    set_vec[BIT_STEP] = step_evt;
    set_vec[BIT_CH0]  = ready_evt[0];
    set_vec[BIT_CH1]  = ready_evt[1];
    set_vec[BIT_ACT]  = act_evt;
    set_vec[BIT_ERR]  = |err_evt;

    clr_vec  = (reg_wr && reg_addr == ADR_STATUS) ? reg_wdata : '0;
    status_d = (status_q & ~clr_vec) | set_vec;
    enable_d = (reg_wr && reg_addr == ADR_ENABLE) ? reg_wdata : enable_q;

    unique case (reg_addr)
      ADR_STATUS: rdata_d = status_q;
      ADR_ENABLE: rdata_d = enable_q;
      ADR_LENGTH: rdata_d = 8'(len_w);
      default:    rdata_d = '0;
    endcase
    if (!reg_rd) rdata_d = rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      status_q <= '0;
      enable_q <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      status_q <= status_d;
      enable_q <= enable_d;
      rdata_q  <= rdata_d;
      rvalid_q <= reg_rd;
    end
  end

  assign reg_rdata  = rdata_q;
  assign reg_rvalid = rvalid_q;
  assign irq        = |(status_q & enable_q);
endmodule

// File: rtl/tdm_event_irq_chk.sv
module tdm_event_irq_chk #(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rst_n_s,
  input logic             bus_err,
  input logic             dma_step,
  input logic [7:0]       status_q,
  input logic [7:0]       enable_q,
  input logic [7:0]       clr_vec,
  input logic [PTR_W-1:0] ptr_w,
  input logic [PTR_W-1:0] len_w,
  input logic             reg_rd,
  input logic             reg_rvalid,
  input logic             irq
);
  logic [7:0] keep;
  assign keep = status_q & ~clr_vec;

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n_s)
    1'b1 |=> ((status_q & $past(keep)) == $past(keep))) else $error("sticky");  // R4

  AST_BUS_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n_s)
    bus_err |=> status_q[0]) else $error("bus err");  // R5

  AST_STEP_SETS_COUNT: assert property (@(posedge clk) disable iff (!rst_n_s)
    dma_step |=> status_q[3]) else $error("step");  // R6

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (len_w >= PTR_W'(2)) |-> (ptr_w < len_w)) else $error("ptr range");  // R6

  AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n_s)
    (enable_q == 8'h00) |-> !irq) else $error("irq gated");  // R3

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n_s)
    reg_rd |=> reg_rvalid) else $error("read latency");  // R2
endmodule

bind tdm_event_irq tdm_event_irq_chk #(.PTR_W(PTR_W)) u_chk (
  .clk        (clk),
  .rst_n_s    (rst_n_s),
  .bus_err    (bus_err),
  .dma_step   (dma_step),
  .status_q   (status_q),
  .enable_q   (enable_q),
  .clr_vec    (clr_vec),
  .ptr_w      (ptr_w),
  .len_w      (len_w),
  .reg_rd     (reg_rd),
  .reg_rvalid (reg_rvalid),
  .irq        (irq)
);

// File: tb/tdm_event_irq_bench.sv
module tdm_event_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_err = 1'b0, dma_step = 1'b0, sclk = 1'b0;
  logic [1:0] rx_fill = '0, rx_take = '0, tx_drain = '0, tx_load = '0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       reg_rvalid;
  logic       irq;

  int checks = 0;
  int fails  = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  tdm_event_irq u_tdm_event_irq (
    .clk(clk), .rst_n(rst_n), .bus_err(bus_err), .dma_step(dma_step),
    .rx_fill(rx_fill), .rx_take(rx_take), .tx_drain(tx_drain), .tx_load(tx_load),
    .sclk(sclk), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .irq(irq)
  );

  // monitor: pops expected reads as the design returns them
  always @(negedge clk) begin
    if (reg_rvalid) begin
      checks++;
      if (sb_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected read data actual=%02h expected=none", reg_rdata);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if (reg_rdata !== it.exp) begin
          fails++;
          $display("FAIL %s actual=%02h expected=%02h", it.tag, reg_rdata, it.exp);
        end
      end
    end
  end

  task automatic rd_expect(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #1 reg_addr = a; reg_rd = 1'b1;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1 reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic check_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, e);
    end
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 dma_step = 1'b1;
      @(posedge clk); #1 dma_step = 1'b0;
    end
  endtask

  task automatic pulse_bus;
    @(posedge clk); #1 bus_err = 1'b1;
    @(posedge clk); #1 bus_err = 1'b0;
  endtask

  task automatic pulse_rx(input logic [1:0] f, input logic [1:0] t);
    @(posedge clk); #1 rx_fill = f; rx_take = t;
    @(posedge clk); #1 rx_fill = '0; rx_take = '0;
  endtask

  task automatic pulse_tx(input logic [1:0] d, input logic [1:0] l);
    @(posedge clk); #1 tx_drain = d; tx_load = l;
    @(posedge clk); #1 tx_drain = '0; tx_load = '0;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rd_expect(2'd0, 8'h00, "R1 status after reset");
    rd_expect(2'd1, 8'h00, "R1 enable after reset");
    rd_expect(2'd2, 8'hFF, "R1 length after reset");
    check_irq(1'b0, "R1 irq after reset");

    // R5 bus error, R3 gating
    pulse_bus();
    rd_expect(2'd0, 8'h01, "R5 bus error sets bit0");
    check_irq(1'b0, "R3 disabled source");
    wr(2'd1, 8'h02);
    check_irq(1'b0, "R3 other enable only");
    wr(2'd1, 8'h01);
    rd_expect(2'd1, 8'h01, "R2 enable readback");
    check_irq(1'b1, "R3 enabled source");
    // R4 clear
    wr(2'd0, 8'h01);
    rd_expect(2'd0, 8'h00, "R4 write one clears");
    check_irq(1'b0, "R4 irq drops after clear");
    // R4 set beats clear
    @(posedge clk); #1 bus_err = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h01; reg_wr = 1'b1;
    @(posedge clk); #1 bus_err = 1'b0; reg_wr = 1'b0;
    rd_expect(2'd0, 8'h01, "R4 set wins over clear");
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'h00);

    // R6 R7 R8 pointer with length 8
    wr(2'd2, 8'd8);
    rd_expect(2'd2, 8'd8, "R2 length readback");
    steps(3);
    rd_expect(2'd0, 8'h08, "R6 step only");
    wr(2'd0, 8'hFF);
    steps(1);
    rd_expect(2'd0, 8'h0A, "R7 halfway at 4 of 8");
    wr(2'd0, 8'hFF);
    steps(3);
    rd_expect(2'd0, 8'h0C, "R8 end at 7 of 8");
    wr(2'd0, 8'hFF);
    steps(1);
    rd_expect(2'd0, 8'h08, "R6 wrap step no half or end");
    wr(2'd0, 8'hFF);
    steps(4);
    rd_expect(2'd0, 8'h0A, "R6 wrapped to zero then half again");
    wr(2'd0, 8'hFF);
    // odd length 5, write restarts pointer
    wr(2'd2, 8'd5);
    steps(2);
    rd_expect(2'd0, 8'h0A, "R7 halfway at 2 of 5");
    wr(2'd0, 8'hFF);
    steps(2);
    rd_expect(2'd0, 8'h0C, "R8 end at 4 of 5");
    wr(2'd0, 8'hFF);

    // R9 channel ready, R10 errors
    pulse_rx(2'b01, 2'b00);
    rd_expect(2'd0, 8'h10, "R9 channel 0 ready");
    wr(2'd0, 8'hFF);
    pulse_rx(2'b00, 2'b01);
    pulse_rx(2'b01, 2'b00);
    rd_expect(2'd0, 8'h10, "R10 taken then refilled no error");
    wr(2'd0, 8'hFF);
    pulse_rx(2'b01, 2'b00);
    rd_expect(2'd0, 8'h90, "R10 overrun sets error");
    wr(2'd0, 8'hFF);
    pulse_rx(2'b10, 2'b00);
    rd_expect(2'd0, 8'h20, "R9 channel 1 ready");
    wr(2'd0, 8'hFF);
    pulse_tx(2'b00, 2'b10);
    pulse_tx(2'b10, 2'b00);
    rd_expect(2'd0, 8'h00, "R10 loaded then drained no error");
    pulse_tx(2'b10, 2'b00);
    rd_expect(2'd0, 8'h80, "R10 underrun sets error");
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'h80);
    check_irq(1'b0, "R3 error enabled but cleared");

    // R11 clock activity
    repeat (40) @(posedge clk);
    rd_expect(2'd0, 8'h00, "R11 quiet clock no activity");
    for (int i = 0; i < 6; i++) begin
      #1 sclk = ~sclk;
      repeat (3) @(posedge clk);
    end
    repeat (40) @(posedge clk);
    rd_expect(2'd0, 8'h40, "R11 toggling clock sets activity");
    wr(2'd0, 8'hFF);
    repeat (40) @(posedge clk);
    rd_expect(2'd0, 8'h00, "R11 stopped clock stays clear");

    repeat (5) @(posedge clk);
    if (sb_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R2 reads missing actual=%0d expected=0", sb_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule